// File: doc/BRIEF.md
# Status Poll Line Driver

This block drives the serial data-out line of a stack-monitor slave for as long as a status poll lasts. The command decoder tells it, with a one-cycle strobe, that a poll has been accepted. It also passes which status is being polled, whether the poll is broadcast, and whether the addressed form names this device. From that cycle until chip select returns high, the line shows the selected status and ignores the serial clock. The two statuses are conversion in progress and any cell out of its voltage window.

A configuration bit picks one of two reporting styles. In toggle style, "not busy" is a square wave built from a clock-enable tick through a divider, and "busy" is a held low. In level style, "busy" pulls the line low and "not busy" lets it go. The line is modelled as open-drain with a pull-up, so several slaves sharing it resolve as a wired-AND. In a broadcast toggle poll only the device marked top of stack makes the square wave; the others let the line go when they are not busy.

Top module: `poll_sdo_driver`

## Requirements
- R1: Out of reset, sdo_oe_o is 0 and sdo_o is 1.
- R2: A poll session starts in the clock edge that samples poll_start_i high while cs_n_i is low. The outputs reflect the poll from the next cycle on. A strobe seen while cs_n_i is high starts nothing.
- R3: While cs_n_i is high, sdo_oe_o is 0 in the same cycle, and the session ends at the next edge. If cs_n_i later goes low with no new strobe, the line is not driven.
- R4: In an active session where this device responds, a set selected status gives sdo_oe_o=1 and sdo_o=0. This holds in both styles.
- R5: In toggle style (level bit 0), a device that responds and is not busy drives sdo_o from a phase bit. The phase is 1 at poll entry and inverts on every DIV_COUNT-th base_tick_i pulse.
- R6: In level style (level bit 1), a device that is not busy releases the line: sdo_oe_o=0 and sdo_o=1. Whenever sdo_oe_o is 0, sdo_o is 1.
- R7: In a broadcast toggle poll, a device that is not busy releases the line when top_of_stack_i is 0 and toggles it when top_of_stack_i is 1. A broadcast poll ignores addr_match_i.
- R8: In an addressed poll (poll_bcast_i=0) whose addr_match_i was 0 at entry, sdo_oe_o stays 0 whatever the status.
- R9: poll_kind_i=0 polls conv_busy_i and poll_kind_i=1 polls irq_active_i. The status that is not selected has no effect.
- R10: Poll kind, broadcast flag, address match and level bit are captured at entry. Changes to them during the session have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| poll_start_i | input | 1 | One-cycle strobe: poll command accepted |
| poll_kind_i | input | 1 | 0 conversion status, 1 interrupt status |
| poll_bcast_i | input | 1 | 1 broadcast poll, 0 addressed poll |
| addr_match_i | input | 1 | Addressed poll names this device |
| conv_busy_i | input | 1 | Conversion in progress |
| irq_active_i | input | 1 | A cell is over or under voltage |
| level_mode_i | input | 1 | 0 toggle style, 1 level style |
| top_of_stack_i | input | 1 | Device is top of stack |
| cs_n_i | input | 1 | Active-low chip select |
| base_tick_i | input | 1 | Clock-enable pulse feeding the toggle divider |
| sdo_o | output | 1 | Value driven on the data-out line (1 when released) |
| sdo_oe_o | output | 1 | Data-out drive enable |

## Verification
The bench counts tick pulses to the exact edge where the phase should flip. A divider that is off by one, or a phase that does not restart at entry, would flip one pulse early or late, or start low. Chip select is raised during a poll and then lowered again with no strobe. A driver that released only at the next edge, or that kept its session, would still pull the shared line. Mid-session changes to the poll kind and to the address match test that they were captured at entry. Broadcast toggle polls with top of stack both clear and set test that only one device makes the square wave.

// File: rtl/poll_drv_pkg.sv
`timescale 1ns/1ps
package poll_drv_pkg;
  typedef enum logic {
    KIND_CONV = 1'b0,
    KIND_IRQ  = 1'b1
  } poll_kind_e;

  typedef struct packed {
    logic       active;
    poll_kind_e kind;
    logic       bcast;
    logic       addr_ok;
    logic       level;
  } poll_sess_t;
endpackage

// File: rtl/poll_session.sv
`timescale 1ns/1ps
module poll_session
  import poll_drv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       start_i,
  input  logic       cs_n_i,
  input  logic       kind_i,
  input  logic       bcast_i,
  input  logic       addr_match_i,
  input  logic       level_i,
  output poll_sess_t sess_o
);
  poll_sess_t sess_q, sess_d;

  always_comb begin
    sess_d = sess_q;
    if (cs_n_i) begin
      sess_d.active = 1'b0;
    end else if (start_i) begin
      sess_d.active  = 1'b1;
      sess_d.kind    = poll_kind_e'(kind_i);
      sess_d.bcast   = bcast_i;
      sess_d.addr_ok = addr_match_i;
      sess_d.level   = level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sess_q <= '{active: 1'b0, kind: KIND_CONV, bcast: 1'b0,
                  addr_ok: 1'b0, level: 1'b0};
    end else begin
      sess_q <= sess_d;
    end
  end

  assign sess_o = sess_q;
endmodule

// File: rtl/poll_phase_gen.sv
`timescale 1ns/1ps
module poll_phase_gen #(
  parameter int DIV_COUNT = 500
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic phase_o
);
  localparam int CNT_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_COUNT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (restart_i) begin
      cnt_d   = '0;
      phase_d = 1'b1;
    end else if (tick_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d   = '0;
        phase_d = ~phase_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/poll_drive_mux.sv
`timescale 1ns/1ps
module poll_drive_mux
  import poll_drv_pkg::*;
(
  input  poll_sess_t sess_i,
  input  logic       cs_n_i,
  input  logic       conv_busy_i,
  input  logic       irq_active_i,
  input  logic       top_of_stack_i,
  input  logic       phase_i,
  output logic       sdo_o,
  output logic       sdo_oe_o
);
  logic responds;
  logic status_set;

  always_comb begin
    responds   = sess_i.active && !cs_n_i && (sess_i.bcast || sess_i.addr_ok);
    status_set = (sess_i.kind == KIND_IRQ) ? irq_active_i : conv_busy_i;
    sdo_oe_o   = 1'b0;
    sdo_o      = 1'b1;
    if (responds) begin
      if (status_set) begin
        sdo_oe_o = 1'b1;
        sdo_o    = 1'b0;
      end else if (!sess_i.level && (!sess_i.bcast || top_of_stack_i)) begin
        sdo_oe_o = 1'b1;
        sdo_o    = phase_i;
      end
    end
  end
endmodule

// File: rtl/poll_sdo_driver.sv
`timescale 1ns/1ps
module poll_sdo_driver
  import poll_drv_pkg::*;
#(
  parameter int DIV_COUNT = 500
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic poll_start_i,
  input  logic poll_kind_i,
  input  logic poll_bcast_i,
  input  logic addr_match_i,
  input  logic conv_busy_i,
  input  logic irq_active_i,
  input  logic level_mode_i,
  input  logic top_of_stack_i,
  input  logic cs_n_i,
  input  logic base_tick_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  poll_sess_t sess;
  logic       phase;
  logic       restart;
  logic       sess_active;
  logic       sess_kind_irq;
  logic       sess_level;

  assign restart       = poll_start_i && !cs_n_i;
  assign sess_active   = sess.active;
  assign sess_kind_irq = (sess.kind == KIND_IRQ);
  assign sess_level    = sess.level;

  poll_session u_session (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .start_i      (poll_start_i),
    .cs_n_i       (cs_n_i),
    .kind_i       (poll_kind_i),
    .bcast_i      (poll_bcast_i),
    .addr_match_i (addr_match_i),
    .level_i      (level_mode_i),
    .sess_o       (sess)
  );

  poll_phase_gen #(.DIV_COUNT(DIV_COUNT)) u_phase (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .restart_i (restart),
    .tick_i    (base_tick_i),
    .phase_o   (phase)
  );

  poll_drive_mux u_mux (
    .sess_i         (sess),
    .cs_n_i         (cs_n_i),
    .conv_busy_i    (conv_busy_i),
    .irq_active_i   (irq_active_i),
    .top_of_stack_i (top_of_stack_i),
    .phase_i        (phase),
    .sdo_o          (sdo_o),
    .sdo_oe_o       (sdo_oe_o)
  );
endmodule

// File: rtl/poll_sdo_driver_chk.sv
`timescale 1ns/1ps
module poll_sdo_driver_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic poll_start,
  input logic base_tick,
  input logic conv_busy,
  input logic irq_active,
  input logic sdo,
  input logic sdo_oe,
  input logic sess_active,
  input logic sess_kind_irq,
  input logic sess_level,
  input logic phase
);
  p_start_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sess_active);

  p_cs_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_oe);

  p_busy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && (sess_kind_irq ? irq_active : conv_busy)) |-> !sdo);

  p_phase_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_start && !cs_n) |=> phase);

  p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick && !poll_start) |=> $stable(phase));

  p_release_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> sdo);

  p_level_no_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && sess_level) |-> !sdo);
endmodule

bind poll_sdo_driver poll_sdo_driver_chk u_chk (
  .clk           (clk_i),
  .rst_n         (rst_n_i),
  .cs_n          (cs_n_i),
  .poll_start    (poll_start_i),
  .base_tick     (base_tick_i),
  .conv_busy     (conv_busy_i),
  .irq_active    (irq_active_i),
  .sdo           (sdo_o),
  .sdo_oe        (sdo_oe_o),
  .sess_active   (sess_active),
  .sess_kind_irq (sess_kind_irq),
  .sess_level    (sess_level),
  .phase         (phase)
);

// File: tb/poll_sdo_driver_bench.sv
`timescale 1ns/1ps
module poll_sdo_driver_bench;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n, poll_start, poll_kind, poll_bcast, addr_match;
  logic conv_busy, irq_active, level_mode, top_of_stack, cs_n, base_tick;
  logic sdo, sdo_oe;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #4 clk = ~clk;

  poll_sdo_driver #(.DIV_COUNT(DIV)) u_poll_sdo_driver (
    .clk_i(clk), .rst_n_i(rst_n), .poll_start_i(poll_start),
    .poll_kind_i(poll_kind), .poll_bcast_i(poll_bcast),
    .addr_match_i(addr_match), .conv_busy_i(conv_busy),
    .irq_active_i(irq_active), .level_mode_i(level_mode),
    .top_of_stack_i(top_of_stack), .cs_n_i(cs_n),
    .base_tick_i(base_tick), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(string req, logic exp_oe, logic exp_sdo);
    n_chk++;
    if (sdo_oe !== exp_oe || sdo !== exp_sdo) begin
      n_bad++;
      $display("FAIL %s: oe/sdo actual %b%b expected %b%b", req, sdo_oe, sdo, exp_oe, exp_sdo);
    end
  endtask

  task automatic idle_inputs();
    poll_start = 0; poll_kind = 0; poll_bcast = 0; addr_match = 1;
    conv_busy = 0; irq_active = 0; level_mode = 0; top_of_stack = 0;
    cs_n = 1; base_tick = 0;
  endtask

  task automatic end_poll();
    cs_n = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic start_poll();
    cs_n = 0;
    poll_start = 1;
    @(negedge clk);
    poll_start = 0;
  endtask

  task automatic pulse_tick();
    base_tick = 1;
    @(negedge clk);
    base_tick = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset", 1'b0, 1'b1);
  endtask

  task automatic t_toggle();
    level_mode = 0; poll_kind = 0; poll_bcast = 0; addr_match = 1;
    start_poll();
    chk("R2 entry phase high", 1'b1, 1'b1);
    pulse_tick(); pulse_tick();
    chk("R5 two ticks no flip", 1'b1, 1'b1);
    pulse_tick();
    chk("R5 third tick flips low", 1'b1, 1'b0);
    repeat (3) pulse_tick();
    chk("R5 back high", 1'b1, 1'b1);
    conv_busy = 1; #1;
    chk("R4 toggle busy low", 1'b1, 1'b0);
    conv_busy = 0;
    end_poll();
  endtask

  task automatic t_level();
    level_mode = 1; poll_kind = 0; poll_bcast = 0; addr_match = 1;
    start_poll();
    level_mode = 0;
    chk("R6 level idle released", 1'b0, 1'b1);
    pulse_tick();
    chk("R10 level bit change ignored", 1'b0, 1'b1);
    conv_busy = 1; #1;
    chk("R4 level busy low", 1'b1, 1'b0);
    conv_busy = 0;
    end_poll();
  endtask

  task automatic t_kind();
    level_mode = 0; poll_kind = 1; poll_bcast = 0; addr_match = 1;
    conv_busy = 1;
    start_poll();
    chk("R9 irq poll ignores conv busy", 1'b1, 1'b1);
    irq_active = 1; #1;
    chk("R9 irq poll reports irq", 1'b1, 1'b0);
    irq_active = 0; conv_busy = 0;
    end_poll();
  endtask

  task automatic t_bcast();
    level_mode = 0; poll_kind = 0; poll_bcast = 1; addr_match = 0;
    top_of_stack = 0;
    start_poll();
    chk("R7 bcast not top released", 1'b0, 1'b1);
    conv_busy = 1; #1;
    chk("R7 bcast not top busy low", 1'b1, 1'b0);
    conv_busy = 0; top_of_stack = 1; #1;
    chk("R7 bcast top toggles", 1'b1, 1'b1);
    repeat (3) pulse_tick();
    chk("R7 bcast top flipped", 1'b1, 1'b0);
    top_of_stack = 0;
    end_poll();
  endtask

  task automatic t_addr_miss();
    level_mode = 0; poll_kind = 0; poll_bcast = 0; addr_match = 0;
    conv_busy = 1;
    start_poll();
    chk("R8 unaddressed busy silent", 1'b0, 1'b1);
    conv_busy = 0; @(negedge clk);
    chk("R8 unaddressed idle silent", 1'b0, 1'b1);
    end_poll();
  endtask

  task automatic t_latch();
    level_mode = 0; poll_kind = 0; poll_bcast = 0; addr_match = 1;
    start_poll();
    poll_kind = 1; addr_match = 0; conv_busy = 1; irq_active = 0;
    @(negedge clk);
    chk("R10 kind and match latched", 1'b1, 1'b0);
    conv_busy = 0;
    end_poll();
  endtask

  task automatic t_cs();
    level_mode = 0; poll_kind = 0; poll_bcast = 0; addr_match = 1;
    start_poll();
    chk("R2 session active", 1'b1, 1'b1);
    cs_n = 1; #1;
    chk("R3 cs high releases at once", 1'b0, 1'b1);
    @(negedge clk);
    cs_n = 0; conv_busy = 1;
    @(negedge clk);
    chk("R3 no re-drive without strobe", 1'b0, 1'b1);
    conv_busy = 0;
    cs_n = 1; poll_start = 1;
    @(negedge clk);
    poll_start = 0; cs_n = 0; conv_busy = 1;
    @(negedge clk);
    chk("R2 strobe with cs high ignored", 1'b0, 1'b1);
    conv_busy = 0;
    end_poll();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_toggle();
    t_level();
    t_kind();
    t_bcast();
    t_addr_miss();
    t_latch();
    t_cs();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule